// File: doc/BRIEF.md
# Chopper Polarity and Frame Sequencer

This block steps an input multiplexer through a configurable number of states per frame, advancing one state per 32 kHz tick. When the final state of a frame ends, it inserts one extra tick period, the settling slot, before the next frame begins. During that slot it holds a frame-sync level high. On the first system clock of the slot it emits a one-cycle start pulse that launches one pass of a downstream compute sequence.

At the moment the settling slot begins, the block samples a 2-bit chop mode and updates a chopper polarity output. The polarity reverses the input pair of a reference amplifier, so alternate polarities average its offset away. Frames are counted to form accumulation intervals of a fixed length. An interval-end level marks the settling slot of the last frame in each interval. The two automatic-toggle modes treat that last frame differently.

The state machine has two states. ST_SCAN covers the normal multiplexer states. ST_SETTLE is the inserted slot. The transition SCAN_TO_SETTLE fires on a tick while the index equals the configured last index. The transition SETTLE_TO_SCAN fires on the next tick.

Top module: `chop_frame_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the state to ST_SCAN and clears the mux index, the frame count and the interval parity. It drives polarity, frame sync, start and interval-end low.
- R2: In ST_SCAN the mux index counts up by one on each clock edge that sees `tick` high, from 0 to `last_idx`. Edges without `tick` leave it unchanged. Frame sync is low in ST_SCAN.
- R3: A tick while the index equals `last_idx` enters ST_SETTLE. ST_SETTLE lasts until the next tick and holds frame sync high and the index at 0. That next tick returns to ST_SCAN at index 0.
- R4: `start` is high for exactly one clock cycle, which is the first clock cycle of ST_SETTLE.
- R5: At the entry to ST_SETTLE, mode 2'b01 sets polarity to 0 and mode 2'b10 sets polarity to 1.
- R6: Polarity changes only at the entry to ST_SETTLE. The mode is sampled only on that edge, so a mode change in the middle of a frame has no effect until the next settling slot.
- R7: Mode 2'b11 inverts polarity at every settling entry except in the last frame of an interval (frame index FRAMES_PER_ACC-1, counted from 0 after reset), where polarity keeps its value.
- R8: Mode 2'b00 inverts polarity at every settling entry except in the last frame of an interval. In that frame, polarity is set to the inverse of an interval parity bit. The parity is 0 after reset and flips as each interval ends, in any mode. Polarity is therefore 1 at the end of the first interval and 0 at the end of the second.
- R9: `acc_end` is high throughout ST_SETTLE of the last frame of each interval and low at all other times.
- R10: With `last_idx` = 0 each frame has a single mux state, and every tick alternates between ST_SCAN and ST_SETTLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | 32 kHz tick enable, one clock wide |
| last_idx | input | IDX_W | Index of the final mux state in a frame |
| chop_mode | input | 2 | Chop mode: 00 auto, 01 low, 10 high, 11 auto hold-at-end |
| mux_idx | output | IDX_W | Current multiplexer state index |
| frame_sync | output | 1 | High during the settling slot |
| start | output | 1 | One-cycle pulse at the rise of frame sync |
| polarity | output | 1 | Chopper polarity |
| acc_end | output | 1 | High in the settling slot of an interval's last frame |

## Verification
The bench builds the block with FRAMES_PER_ACC = 3 and MAX_STATES = 16. Six frames therefore span two full accumulation intervals, which exposes both the hold in mode 11 and the alternating end value of mode 00 within a few hundred cycles. `last_idx` is set to 3 for most tests and to 0 for the single-state boundary. Ticks are spaced by idle clocks, so the one-cycle start pulse can be told apart from the longer frame-sync level.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;

    typedef enum logic {
        ST_SCAN   = 1'b0,
        ST_SETTLE = 1'b1
    } seq_state_e;

    typedef enum logic [1:0] {
        CM_AUTO_ALT  = 2'b00,
        CM_FIX_LOW   = 2'b01,
        CM_FIX_HIGH  = 2'b10,
        CM_AUTO_HOLD = 2'b11
    } chop_mode_e;

endpackage

// File: rtl/seq_fsm.sv
module seq_fsm
    import chop_seq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] mux_idx,
    output logic             frame_sync,
    output logic             start,
    output logic             enter_settle,
    output logic             leave_settle
);

    seq_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_SCAN: begin
                if (tick) begin
                    if (idx_q == last_idx) begin
                        state_d = ST_SETTLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_SETTLE: begin
                if (tick) begin
                    state_d = ST_SCAN;
                    idx_d   = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SCAN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        enter_settle = (state_q == ST_SCAN) && (state_d == ST_SETTLE);
        leave_settle = (state_q == ST_SETTLE) && (state_d == ST_SCAN);
        frame_sync   = (state_q == ST_SETTLE);
        mux_idx      = idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) start <= 1'b0;
        else     start <= enter_settle;
    end

    AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        start |-> frame_sync);                                   // R4
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);                                       // R4
    AST_SYNC_RISE_START: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> start);                            // R4
    AST_IDX_ZERO_SETTLE: assert property (@(posedge clk) disable iff (rst)
        frame_sync |-> (mux_idx == '0));                         // R3
    AST_IDX_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mux_idx));                             // R2

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker #(
    parameter int FRAMES_PER_ACC = 4,
    localparam int FCW = (FRAMES_PER_ACC > 1) ? $clog2(FRAMES_PER_ACC) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic leave_settle,
    input  logic frame_sync,
    output logic last_frame,
    output logic parity,
    output logic acc_end
);

    localparam logic [FCW-1:0] LAST_F = FCW'(FRAMES_PER_ACC - 1);

    logic [FCW-1:0] fcnt_q;

    assign last_frame = (fcnt_q == LAST_F);

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt_q <= '0;
            parity <= 1'b0;
        end else if (leave_settle) begin
            if (last_frame) begin
                fcnt_q <= '0;
                parity <= ~parity;
            end else begin
                fcnt_q <= fcnt_q + 1'b1;
            end
        end
    end

    always_comb acc_end = frame_sync && last_frame;

    AST_ACC_END_IN_SYNC: assert property (@(posedge clk) disable iff (rst)
        acc_end |-> frame_sync);                                 // R9
    AST_PARITY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        !$stable(parity) |-> $past(leave_settle && last_frame)); // R8

endmodule

// File: rtl/pol_ctrl.sv
module pol_ctrl
    import chop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enter_settle,
    input  logic [1:0] chop_mode,
    input  logic       last_frame,
    input  logic       parity,
    output logic       polarity
);

    chop_mode_e mode;
    logic       pol_d;

    always_comb begin
        mode  = chop_mode_e'(chop_mode);
        pol_d = polarity;
        unique case (mode)
            CM_FIX_LOW:   pol_d = 1'b0;
            CM_FIX_HIGH:  pol_d = 1'b1;
            CM_AUTO_HOLD: pol_d = last_frame ? polarity : ~polarity;
            CM_AUTO_ALT:  pol_d = last_frame ? ~parity  : ~polarity;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)               polarity <= 1'b0;
        else if (enter_settle) polarity <= pol_d;
    end

    AST_MODE_LOW: assert property (@(posedge clk) disable iff (rst)
        (enter_settle && chop_mode == 2'b01) |=> !polarity);     // R5
    AST_MODE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (enter_settle && chop_mode == 2'b10) |=> polarity);      // R5
    AST_HOLD_AT_END: assert property (@(posedge clk) disable iff (rst)
        (enter_settle && chop_mode == 2'b11 && last_frame)
        |=> $stable(polarity));                                  // R7

endmodule

// File: rtl/chop_frame_seq.sv
module chop_frame_seq #(
    parameter int MAX_STATES     = 16,
    parameter int FRAMES_PER_ACC = 4,
    localparam int IDX_W = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [1:0]       chop_mode,
    output logic [IDX_W-1:0] mux_idx,
    output logic             frame_sync,
    output logic             start,
    output logic             polarity,
    output logic             acc_end
);

    logic enter_settle, leave_settle, last_frame, parity;

    seq_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .last_idx     (last_idx),
        .mux_idx      (mux_idx),
        .frame_sync   (frame_sync),
        .start        (start),
        .enter_settle (enter_settle),
        .leave_settle (leave_settle)
    );

    frame_tracker #(.FRAMES_PER_ACC(FRAMES_PER_ACC)) u_frames (
        .clk          (clk),
        .rst          (rst),
        .leave_settle (leave_settle),
        .frame_sync   (frame_sync),
        .last_frame   (last_frame),
        .parity       (parity),
        .acc_end      (acc_end)
    );

    pol_ctrl u_pol (
        .clk          (clk),
        .rst          (rst),
        .enter_settle (enter_settle),
        .chop_mode    (chop_mode),
        .last_frame   (last_frame),
        .parity       (parity),
        .polarity     (polarity)
    );

    AST_POL_ONLY_AT_SETTLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(polarity) |-> $rose(frame_sync));               // R6
    AST_SYNC_LOW_AFTER_RST: assert property (@(posedge clk)
        $past(rst) |-> (!frame_sync && !polarity && mux_idx == '0)); // R1

endmodule

// File: tb/sim_chop_frame_seq.sv
module sim_chop_frame_seq;

    localparam int MS = 16;
    localparam int FA = 3;
    localparam int IW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [IW-1:0] last_idx = 4'd3;
    logic [1:0] chop_mode = 2'b01;
    logic [IW-1:0] mux_idx;
    logic frame_sync, start, polarity, acc_end;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int exp_pol, exp_par, fcnt;

    always #5 clk = ~clk;

    chop_frame_seq #(.MAX_STATES(MS), .FRAMES_PER_ACC(FA)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .last_idx(last_idx),
        .chop_mode(chop_mode), .mux_idx(mux_idx), .frame_sync(frame_sync),
        .start(start), .polarity(polarity), .acc_end(acc_end)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [IW-1:0] li);
        @(negedge clk);
        rst = 1'b1;
        last_idx = li;
        tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_pol = 0; exp_par = 0; fcnt = 0;
    endtask

    task automatic tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic test_reset();
        chk(mux_idx == 0, "R1", "idx after reset", int'(mux_idx), 0);
        chk(frame_sync == 0, "R1", "sync after reset", int'(frame_sync), 0);
        chk(polarity == 0, "R1", "pol after reset", int'(polarity), 0);
        chk(start == 0 && acc_end == 0, "R1", "start/acc_end after reset",
            int'(start) + int'(acc_end), 0);
    endtask

    task automatic test_no_tick();
        tick_once();
        repeat (6) @(negedge clk);
        chk(mux_idx == 1, "R2", "idx held without tick", int'(mux_idx), 1);
    endtask

    // one frame; mode_a at start, mode_b after the first tick
    task automatic run_frame(input logic [1:0] mode_a, input logic [1:0] mode_b);
        int nst;
        bit last;
        int pol0;
        nst = int'(last_idx) + 1;
        chop_mode = mode_a;
        pol0 = int'(polarity);
        for (int i = 0; i < nst; i++) begin
            chk(mux_idx == i[IW-1:0], "R2", "mux index", int'(mux_idx), i);
            chk(frame_sync == 0, "R2", "sync low in scan", int'(frame_sync), 0);
            chk(int'(polarity) == pol0, "R6", "pol stable in frame", int'(polarity), pol0);
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            if (i == 0) chop_mode = mode_b;
            @(negedge clk);
        end
        last = (fcnt == FA - 1);
        case (mode_b)
            2'b01: exp_pol = 0;
            2'b10: exp_pol = 1;
            2'b11: exp_pol = last ? exp_pol : 1 - exp_pol;
            default: exp_pol = last ? 1 - exp_par : 1 - exp_pol;
        endcase
        if (last) exp_par = 1 - exp_par;
        chk(frame_sync == 1, "R3", "sync in settle", int'(frame_sync), 1);
        chk(mux_idx == 0, "R3", "idx in settle", int'(mux_idx), 0);
        chk(int'(polarity) == exp_pol, (mode_b == 2'b00) ? "R8" :
            (mode_b == 2'b11) ? "R7" : "R5", "polarity at settle",
            int'(polarity), exp_pol);
        chk(int'(acc_end) == int'(last), "R9", "acc_end in settle",
            int'(acc_end), int'(last));
        fcnt = last ? 0 : fcnt + 1;
    endtask

    // start pulse is seen only in the first clock of settle
    task automatic test_start_pulse();
        chop_mode = 2'b01;
        for (int i = 0; i < int'(last_idx); i++) tick_once();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        chk(start == 1, "R4", "start at settle entry", int'(start), 1);
        @(negedge clk);
        chk(start == 0, "R4", "start one cycle", int'(start), 0);
        chk(frame_sync == 1, "R4", "sync outlasts start", int'(frame_sync), 1);
        tick_once();
        chk(frame_sync == 0 && mux_idx == 0, "R3", "back to scan",
            int'(frame_sync), 0);
        fcnt = fcnt + 1; exp_pol = 0;
    endtask

    task automatic test_single_state();
        do_reset(4'd0);
        for (int k = 0; k < 4; k++) begin
            chk(frame_sync == 0, "R10", "single state scan", int'(frame_sync), 0);
            run_frame(2'b11, 2'b11);
            chk(frame_sync == 1, "R10", "single state settle", int'(frame_sync), 1);
            tick_once();
        end
    endtask

    initial begin
        do_reset(4'd3);
        test_reset();
        test_no_tick();
        do_reset(4'd3);
        test_start_pulse();
        // fixed modes
        run_frame(2'b10, 2'b10); tick_once();
        run_frame(2'b01, 2'b01); tick_once();
        // mid-frame mode change only takes effect at settle
        run_frame(2'b01, 2'b10); tick_once();
        // hold-at-end toggle mode, two intervals
        for (int k = 0; k < 6; k++) begin run_frame(2'b11, 2'b11); tick_once(); end
        // reset from polarity high
        run_frame(2'b10, 2'b10);
        do_reset(4'd3);
        test_reset();
        // alternating mode, two intervals from a clean parity
        for (int k = 0; k < 6; k++) begin
            run_frame(2'b00, 2'b00);
            if (k == 2) chk(polarity == 1, "R8", "end of first interval", int'(polarity), 1);
            if (k == 5) chk(polarity == 0, "R8", "end of second interval", int'(polarity), 0);
            tick_once();
        end
        test_single_state();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule